// File: doc/BRIEF.md
# Synchronized Input Glitch Filter

This block cleans up a single asynchronous input bit so that logic in the clock domain can use it. The raw bit is first retimed through a flop chain of at least two stages. Only the last flop of that chain is seen by the rest of the filter. The synchronized sample then shifts into a history register, one sample per clock. A voting stage looks at the newest `DEPTH` synchronized samples. It moves the filtered level only when all of them agree, and otherwise keeps the level it already has.

A level change on the raw input therefore reaches the output after the synchronizer delay plus the filter window. Any excursion shorter than the window is discarded. An optional one-cycle strobe marks each accepted rising edge of the filtered level. `DEPTH` must lie between 2 and 32, and the synchronizer needs at least two stages. Values outside these limits stop elaboration with an error.

Top module: `glitch_gate`

## Requirements
- R1: When `rst` is high at a rising clock edge, all synchronizer flops, the history register, `level_o` and `rise_o` are cleared to 0. If `raw_i` is held at 1 through reset and afterwards, `level_o` rises at the 2+DEPTH-th edge after `rst` falls.
- R2: When `raw_i` goes from 0 to 1 and stays there for at least DEPTH cycles, `level_o` becomes 1 after the 2+DEPTH-th rising edge. The count starts with the first edge that samples the new level.
- R3: When `raw_i` goes from 1 to 0 and stays there for at least DEPTH cycles, `level_o` becomes 0 after the 2+DEPTH-th rising edge. The count starts the same way as in R2.
- R4: While `level_o` is 0, a high excursion of `raw_i` that lasts fewer than DEPTH cycles leaves `level_o` at 0.
- R5: While `level_o` is 1, a low excursion of `raw_i` that lasts fewer than DEPTH cycles leaves `level_o` at 1.
- R6: `level_o` changes only when the newest DEPTH synchronized samples are all equal. At every other time it keeps its previous value.
- R7: With `EDGE_PULSE` = 1, `rise_o` is 1 for exactly the one cycle in which `level_o` has just gone from 0 to 1. It is 0 on falling transitions and while the level stays high.
- R8: A high excursion of `raw_i` lasting exactly DEPTH cycles is accepted, and `level_o` goes to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_i | input | 1 | Asynchronous raw input bit |
| level_o | output | 1 | Filtered, synchronized level |
| rise_o | output | 1 | One-cycle strobe on each accepted rising edge of `level_o` |

## Verification
The main stimulus is a single table-driven sequence with DEPTH = 4. It contains high and low excursions one cycle shorter than the window, which must be rejected. It also contains an excursion exactly as long as the window, which must pass, separating a correct vote from an off-by-one window. Patterns that alternate inside the window show that the stage holds its level when the samples disagree. A re-entry to a level that is already held must produce no second strobe.

Directed runs then cover the following:
- reset while the output is high, followed by the exact edge at which the output comes back, which exposes any synchronizer flop that reset misses;
- a clean fall, which must produce no strobe.

// File: rtl/gf_pkg.sv
package gf_pkg;

    localparam int unsigned GF_MIN_DEPTH = 2;
    localparam int unsigned GF_MAX_DEPTH = 32;
    localparam int unsigned GF_MIN_SYNC  = 2;

    typedef struct packed {
        logic level;
        logic rise;
    } gf_out_t;

endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    // Only chain[0] sees the asynchronous bit; it feeds chain[1] alone.
    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
        if (rst) begin
            st_d.chain = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

    // R1
    sync_reset_chk: assert property (@(posedge clk) rst |=> (st_q.chain == '0))
        else $error("synchronizer not cleared by reset");

endmodule

// File: rtl/gf_window.sv
module gf_window #(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    output logic [DEPTH-1:0] window_o
);

    localparam int unsigned HIST_W = DEPTH - 1;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [HIST_W-1:0] shifted;

    generate
        if (HIST_W == 1) begin : g_single
            assign shifted = sample_i;
        end else begin : g_multi
            assign shifted = {st_q.hist[HIST_W-2:0], sample_i};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        st_d.hist = shifted;
        if (rst) begin
            st_d.hist = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Newest sample in bit 0: the contents the register will hold after this edge.
    assign window_o = {st_q.hist, sample_i};

    // R6
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (st_q.hist[0] == $past(sample_i)))
        else $error("history register did not take the synchronized sample");

endmodule

// File: rtl/gf_vote.sv
module gf_vote
    import gf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] window_i,
    output gf_out_t          out_o
);

    gf_out_t st_d, st_q;
    logic    all_high;
    logic    all_low;

    assign all_high = &window_i;
    assign all_low  = ~|window_i;

    always_comb begin
        st_d = st_q;
        if (all_high) begin
            st_d.level = 1'b1;
        end else if (all_low) begin
            st_d.level = 1'b0;
        end
        st_d.rise = st_d.level & ~st_q.level;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_o = st_q;

    // R6
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_q.level && !all_high) |=> !st_q.level)
        else $error("level rose without a unanimous high window");

    // R6
    hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.level && !all_low) |=> st_q.level)
        else $error("level fell without a unanimous low window");

    // R7
    rise_only_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.rise |-> (st_q.level && !$past(st_q.level)))
        else $error("strobe without a fresh rising level");

    // R7
    edge_gives_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.level) |-> st_q.rise)
        else $error("rising level without strobe");

endmodule

// File: rtl/glitch_gate.sv
module glitch_gate
    import gf_pkg::*;
#(
    parameter int unsigned DEPTH       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          EDGE_PULSE  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o
);

    generate
        if (DEPTH < GF_MIN_DEPTH || DEPTH > GF_MAX_DEPTH) begin : g_bad_depth
            $error("glitch_gate: DEPTH must lie in [2, 32]");
        end
        if (SYNC_STAGES < GF_MIN_SYNC) begin : g_bad_sync
            $error("glitch_gate: SYNC_STAGES must be at least 2");
        end
    endgenerate

    logic             synced;
    logic [DEPTH-1:0] window;
    gf_out_t          vote;

    gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_i),
        .sync_o  (synced)
    );

    gf_window #(.DEPTH(DEPTH)) u_window (
        .clk      (clk),
        .rst      (rst),
        .sample_i (synced),
        .window_o (window)
    );

    gf_vote #(.DEPTH(DEPTH)) u_vote (
        .clk      (clk),
        .rst      (rst),
        .window_i (window),
        .out_o    (vote)
    );

    assign level_o = vote.level;

    generate
        if (EDGE_PULSE) begin : g_pulse
            assign rise_o = vote.rise;
        end else begin : g_no_pulse
            assign rise_o = 1'b0;
        end
    endgenerate

    // R7
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o)
        else $error("strobe lasted more than one cycle");

    // R1
    out_reset_chk: assert property (@(posedge clk) rst |=> (!level_o && !rise_o))
        else $error("outputs not cleared by reset");

endmodule

// File: tb/sim_glitch_gate.sv
module sim_glitch_gate;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int NV         = 50;

    // Each entry: {raw_i, expected level_o, expected rise_o}, DEPTH = 4.
    localparam logic [2:0] VEC [NV] = '{
        3'b000, 3'b000, 3'b000,                 // 0-2 idle low
        3'b100, 3'b100, 3'b100,                 // 3-5 short high, rejected (R4)
        3'b000, 3'b000,                         // 6-7
        3'b100, 3'b100, 3'b100, 3'b100,         // 8-11 exactly DEPTH high (R8)
        3'b000, 3'b011,                         // 12-13 level rises at 13 (R2, R7)
        3'b110, 3'b010, 3'b010, 3'b010,         // 14-17 mixed window holds (R6)
        3'b010, 3'b010,                         // 18-19
        3'b000, 3'b000, 3'b000, 3'b000,         // 20-23 level falls at 20 (R3)
        3'b100, 3'b100, 3'b100, 3'b100,         // 24-27
        3'b100, 3'b111, 3'b110, 3'b110,         // 28-31 rise at 29
        3'b010, 3'b010, 3'b010,                 // 32-34 short low, rejected (R5)
        3'b110, 3'b110, 3'b110, 3'b110,         // 35-38
        3'b110, 3'b110,                         // 39-40 re-agreement, no strobe (R7)
        3'b010, 3'b010, 3'b010, 3'b010, 3'b010, // 41-45
        3'b000, 3'b000, 3'b000, 3'b000          // 46-49 fall, no strobe (R3)
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw = 1'b0;
    logic level;
    logic rise;

    int applied = 0;
    int bad     = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    glitch_gate #(.DEPTH(N), .SYNC_STAGES(2), .EDGE_PULSE(1'b1)) u0 (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (raw),
        .level_o (level),
        .rise_o  (rise)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        applied++;
        bad++;
        $display("FAIL watchdog: actual running expected finished");
        wrap_up();
    end

    initial begin
        rst = 1'b1;
        raw = 1'b0;
        repeat (3) step();
        check("R1", "level in reset", level, 1'b0);
        check("R1", "rise in reset", rise, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            raw = VEC[i][2];
            step();
            check("R6", $sformatf("level vec %0d", i), level, VEC[i][1]);
            check("R7", $sformatf("rise vec %0d", i), rise, VEC[i][0]);
        end

        // R1: reset while high, then exact return time with input held high
        raw = 1'b1;
        repeat (N + 2) step();
        check("R2", "level before reset", level, 1'b1);
        rst = 1'b1;
        step();
        check("R1", "level after reset edge", level, 1'b0);
        check("R1", "rise after reset edge", rise, 1'b0);
        rst = 1'b0;
        for (int k = 0; k < N + 3; k++) begin
            step();
            check("R1", $sformatf("level edge %0d after release", k), level, (k >= N + 1));
            check("R1", $sformatf("rise edge %0d after release", k), rise, (k == N + 1));
        end

        // R3: clean fall, exact latency and no strobe
        raw = 1'b0;
        for (int k = 0; k < N + 4; k++) begin
            step();
            check("R3", $sformatf("level edge %0d of fall", k), level, (k < N + 1));
            check("R7", $sformatf("rise edge %0d of fall", k), rise, 1'b0);
        end

        // R4: one-cycle spike while low
        raw = 1'b1;
        step();
        raw = 1'b0;
        for (int k = 0; k < 2 * N + 4; k++) begin
            step();
            check("R4", $sformatf("level after spike %0d", k), level, 1'b0);
        end

        wrap_up();
    end

endmodule